// File: doc/BRIEF.md
# Virtual Input/Output Bank with Transition Capture

This block connects a host register port to a bank of synchronous inputs and a bank of synchronous outputs. Both sides share one clock. On the input side it samples every input on each clock edge. It also keeps two sticky flags per input, one for rising transitions and one for falling transitions. A host that polls only now and then still learns that a signal toggled, even when the signal has already returned to its old level. Reading a flag word returns the flags and clears them. A transition detected in the same cycle as that read is kept for the next read.

On the output side each lane is a register on the design clock. The host can set a lane to a fixed level. It can also load a 16-bit pattern that the lane plays out once, one bit per cycle starting with bit 0. After the last bit the lane keeps that bit until the host writes to the lane again.

The host issues one-cycle read or write strobes with an 8-bit address. Read data is registered: it appears on the edge that follows the read strobe and holds until the next read.

Top module: `vio_port_bank`

## Requirements
- R1: While reset is low and just after it is released, every output lane is 0, every flag is clear, no lane is busy, and read data is 0.
- R2: A read of address 0x00 returns, in bits [N_IN-1:0], the inputs as sampled on the edge before the read edge. Data appears after the read edge.
- R3: Address 0x01 holds one rising flag per input. A flag is set when the sampled input goes from 0 to 1 and stays set until the host reads 0x01. That read returns the flags and clears them, except for a rise detected in the read cycle itself, which stays set.
- R4: Address 0x02 holds one falling flag per input and behaves like R3 for transitions from 1 to 0.
- R5: A read of one flag address leaves the other flag word untouched.
- R6: A write to 0x10+k drives lane k to wdata[0] from the write edge on. This cancels any pattern in progress.
- R7: A write to 0x20+k loads wdata[15:0] into lane k. The lane shows bit 0 in the cycle after the write edge and bit j in the j-th cycle after that. A new load while the lane is playing restarts it with the new pattern.
- R8: After bit 15 the lane holds bit 15 and does not repeat the pattern until the next write to that lane.
- R9: A read of 0x03 returns the current output lanes in bits [N_OUT-1:0]. A read of 0x04 returns one busy bit per lane, set while the lane is showing bits 0 to 14 of a pattern.
- R10: Writes to read-only addresses, to unmapped addresses, or to lane numbers at or above N_OUT change no output and no flag.
- R11: Read data holds its value in every cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | N_IN | Monitored inputs |
| sync_out | output | N_OUT | Driven output lanes |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 8 | Host register address |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Registered host read data |

## Verification
The assertions assume that the host never writes to the level address and the pattern address of one lane in the same cycle. This holds because a single address is decoded per strobe. They also assume that the inputs are already synchronous to the clock, so the sampled value equals the value driven before the edge. The stimulus changes inputs and strobes only on the falling edge. It holds the inputs steady during every read whose result is predicted. It lets each pattern finish before another lane is loaded, except in the directed cases that cancel or restart a pattern.

// File: rtl/vio_pkg.sv
package vio_pkg;
    // Register addresses decoded by the host port
    localparam logic [7:0] A_IN_VAL  = 8'h00;
    localparam logic [7:0] A_RISE    = 8'h01;
    localparam logic [7:0] A_FALL    = 8'h02;
    localparam logic [7:0] A_OUT_VAL = 8'h03;
    localparam logic [7:0] A_BUSY    = 8'h04;

    // Upper address nibble selecting a per-lane page, lower nibble the lane
    localparam logic [3:0] PG_LEVEL   = 4'h1;
    localparam logic [3:0] PG_PATTERN = 4'h2;

    localparam int unsigned MAX_LANES = 16;
endpackage

// File: rtl/vio_in_monitor.sv
module vio_in_monitor #(
    parameter int unsigned N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] sig_in,
    input  logic            clr_rise,
    input  logic            clr_fall,
    output logic [N_IN-1:0] val_q,
    output logic [N_IN-1:0] rise_q,
    output logic [N_IN-1:0] fall_q
);
    typedef struct packed {
        logic [N_IN-1:0] val;
        logic [N_IN-1:0] rise;
        logic [N_IN-1:0] fall;
    } mon_t;

    mon_t st_d, st_q;
    logic [N_IN-1:0] up_now, dn_now;

    always_comb begin
        up_now     = sig_in & ~st_q.val;
        dn_now     = ~sig_in & st_q.val;
        st_d       = st_q;
        st_d.val   = sig_in;
        // flags reported by a read are dropped, fresh edges survive
        st_d.rise  = (clr_rise ? '0 : st_q.rise) | up_now;
        st_d.fall  = (clr_fall ? '0 : st_q.fall) | dn_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_q  = st_q.val;
    assign rise_q = st_q.rise;
    assign fall_q = st_q.fall;

    // R3: a rising flag is never lost without a read of the rise word
    a_r3_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_rise |=> (($past(rise_q) & ~rise_q) == '0));
    // R4: same for falling flags
    a_r4_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_fall |=> (($past(fall_q) & ~fall_q) == '0));
    // R3: a flag newly set must coincide with the sampled value rising
    a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_q & ~$past(rise_q) & ~(val_q & ~$past(val_q))) == '0));
    // R4: a newly set fall flag must coincide with the sampled value falling
    a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fall_q & ~$past(fall_q) & ~(~val_q & $past(val_q))) == '0));
endmodule

// File: rtl/vio_out_lane.sv
module vio_out_lane #(
    parameter int unsigned PAT_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_lvl,
    input  logic               lvl,
    input  logic               load_pat,
    input  logic [PAT_LEN-1:0] pat,
    output logic               out_q,
    output logic               busy
);
    localparam int unsigned CW = $clog2(PAT_LEN);

    typedef struct packed {
        logic               drv;
        logic [PAT_LEN-1:0] sh;
        logic [CW-1:0]      left;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_pat) begin
            st_d.drv  = pat[0];
            st_d.sh   = pat >> 1;
            st_d.left = CW'(PAT_LEN - 1);
        end else if (set_lvl) begin
            st_d.drv  = lvl;
            st_d.sh   = '0;
            st_d.left = '0;
        end else if (st_q.left != '0) begin
            st_d.drv  = st_q.sh[0];
            st_d.sh   = st_q.sh >> 1;
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_q = st_q.drv;
    assign busy  = (st_q.left != '0);

    // R6: a level write lands on the next edge and stops any playback
    a_r6_level_applied: assert property (@(posedge clk) disable iff (!rst_n)
        (set_lvl && !load_pat) |=> (out_q == $past(lvl)) && !busy);
    // R7: the first pattern bit follows the load edge
    a_r7_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        load_pat |=> (out_q == $past(pat[0])) && busy);
    // R8: an idle lane with no write keeps its value
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !set_lvl && !load_pat) |=> $stable(out_q));
endmodule

// File: rtl/vio_port_bank.sv
module vio_port_bank #(
    parameter int unsigned N_IN    = 8,
    parameter int unsigned N_OUT   = 4,
    parameter int unsigned DW      = 16,
    parameter int unsigned PAT_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  sync_in,
    output logic [N_OUT-1:0] sync_out,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata
);
    import vio_pkg::*;

    localparam int unsigned LANE_IDX_W = 4;

    initial begin
        if (N_IN > DW || N_OUT > DW || N_OUT > MAX_LANES || PAT_LEN > DW || PAT_LEN < 2)
            $error("vio_port_bank: parameter set out of range");
    end

    typedef struct packed {
        logic [DW-1:0] rdata;
    } host_t;

    host_t st_d, st_q;

    logic [N_IN-1:0]  mon_val, mon_rise, mon_fall;
    logic [N_OUT-1:0] lane_busy, lvl_hit, pat_hit;
    logic             clr_rise, clr_fall;
    logic [DW-1:0]    w_in, w_rise, w_fall, w_out, w_busy;

    assign clr_rise = reg_rd && (reg_addr == A_RISE);
    assign clr_fall = reg_rd && (reg_addr == A_FALL);

    vio_in_monitor #(.N_IN(N_IN)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sync_in),
        .clr_rise (clr_rise),
        .clr_fall (clr_fall),
        .val_q    (mon_val),
        .rise_q   (mon_rise),
        .fall_q   (mon_fall)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_lane
        assign lvl_hit[k] = reg_wr && (reg_addr[7:4] == PG_LEVEL)
                            && (reg_addr[3:0] == LANE_IDX_W'(k));
        assign pat_hit[k] = reg_wr && (reg_addr[7:4] == PG_PATTERN)
                            && (reg_addr[3:0] == LANE_IDX_W'(k));
        vio_out_lane #(.PAT_LEN(PAT_LEN)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_lvl  (lvl_hit[k]),
            .lvl      (reg_wdata[0]),
            .load_pat (pat_hit[k]),
            .pat      (reg_wdata[PAT_LEN-1:0]),
            .out_q    (sync_out[k]),
            .busy     (lane_busy[k])
        );
    end

    always_comb begin
        w_in   = '0;  w_in[N_IN-1:0]    = mon_val;
        w_rise = '0;  w_rise[N_IN-1:0]  = mon_rise;
        w_fall = '0;  w_fall[N_IN-1:0]  = mon_fall;
        w_out  = '0;  w_out[N_OUT-1:0]  = sync_out;
        w_busy = '0;  w_busy[N_OUT-1:0] = lane_busy;
    end

    always_comb begin
        st_d = st_q;
        if (reg_rd) begin
            unique case (reg_addr)
                A_IN_VAL:  st_d.rdata = w_in;
                A_RISE:    st_d.rdata = w_rise;
                A_FALL:    st_d.rdata = w_fall;
                A_OUT_VAL: st_d.rdata = w_out;
                A_BUSY:    st_d.rdata = w_busy;
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    // R11: read data only moves on a read strobe
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
    // R5: reading the rise word leaves the fall flags intact
    a_r5_fall_kept: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> (($past(mon_fall) & ~mon_fall) == '0));
    // R10: a write outside the lane pages never moves the outputs of idle lanes
    a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[7:4] != PG_LEVEL && reg_addr[7:4] != PG_PATTERN
         && lane_busy == '0) |=> $stable(sync_out));
endmodule

// File: tb/vio_port_bank_test.sv
`timescale 1ns/1ps
module vio_port_bank_test;
    localparam int N_IN = 8, N_OUT = 4, DW = 16;

    logic clk = 0, rst_n = 0;
    logic [N_IN-1:0]  sync_in = '0;
    logic [N_OUT-1:0] sync_out;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;

    vio_port_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .PAT_LEN(16)) uut (
        .clk, .rst_n, .sync_in, .sync_out, .reg_wr, .reg_rd,
        .reg_addr, .reg_wdata, .reg_rdata);

    always #2 clk = ~clk;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [N_IN-1:0]  m_val = '0, m_rise = '0, m_fall = '0;
    logic [N_OUT-1:0] m_out = '0;
    logic [DW-1:0] d;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic pat_bit(logic [15:0] p, int j);
        return (j < 16) ? p[j] : p[15];
    endfunction

    task automatic set_in(logic [N_IN-1:0] v);
        sync_in = v;
        @(negedge clk);
        m_rise |= v & ~m_val;
        m_fall |= ~v & m_val;
        m_val = v;
    endtask

    task automatic rd(logic [7:0] a, output logic [DW-1:0] q);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        q = reg_rdata; reg_rd = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [DW-1:0] v);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic chk_flags();
        rd(8'h01, d); chk("R3 rise flags", d, {8'h0, m_rise}); m_rise = '0;
        rd(8'h02, d); chk("R4 fall flags", d, {8'h0, m_fall}); m_fall = '0;
    endtask

    task automatic play(int k, logic [15:0] p);
        wr(8'h20 + 8'(k), p);
        for (int j = 0; j < 20; j++) begin
            logic [N_OUT-1:0] e;
            e = m_out; e[k] = pat_bit(p, j);
            chk(j < 16 ? "R7 pattern bit" : "R8 hold last bit", sync_out, e);
            @(negedge clk);
        end
        m_out[k] = p[15];
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", sync_out, 0);
        chk("R1 reset rdata", reg_rdata, 0);
        rst_n = 1;
        @(negedge clk);
        rd(8'h01, d); chk("R1 rise clear after reset", d, 0);
        rd(8'h04, d); chk("R1 no lane busy", d, 0);

        // R2 value readback
        set_in(8'hA5); @(negedge clk);
        rd(8'h00, d); chk("R2 input value", d, 16'h00A5);

        // R3/R4: short pulse that returns to its old level is still seen
        set_in(8'hA7); set_in(8'hA5);
        chk_flags();
        rd(8'h01, d); chk("R3 rise cleared by read", d, 0);

        // R5: rise read leaves fall flags
        set_in(8'h0F); set_in(8'hF0);
        rd(8'h01, d); chk("R5 rise word", d, {8'h0, m_rise}); m_rise = '0;
        rd(8'h02, d); chk("R5 fall kept", d, {8'h0, m_fall}); m_fall = '0;

        // R3: rise arriving in the read cycle survives the clear
        sync_in = 8'hF3; reg_rd = 1; reg_addr = 8'h01;
        @(negedge clk);
        chk("R3 read returns old flags", reg_rdata, {8'h0, m_rise});
        reg_rd = 0;
        m_fall = m_fall | (~8'hF3 & m_val);
        m_rise = 8'hF3 & ~m_val; m_val = 8'hF3;
        rd(8'h01, d); chk("R3 rise in read cycle kept", d, {8'h0, m_rise}); m_rise = '0;
        rd(8'h02, d); m_fall = '0;

        // R11: read data holds without read strobe
        rd(8'h00, d);
        set_in(8'h11); set_in(8'h22);
        chk("R11 rdata holds", reg_rdata, d);
        chk_flags();

        // R6/R9 level writes and readback
        wr(8'h12, 16'h0001); m_out[2] = 1;
        chk("R6 level high", sync_out, m_out);
        rd(8'h03, d); chk("R9 output readback", d, {12'h0, m_out});

        // R7/R8/R9 pattern playback with busy readback
        wr(8'h21, 16'h8001);
        chk("R7 first bit", sync_out[1], 1);
        rd(8'h04, d); chk("R9 busy while playing", d, 16'h0002);
        repeat (20) @(negedge clk);
        m_out[1] = 1;
        rd(8'h04, d); chk("R9 idle after pattern", d, 0);
        chk("R8 holds bit 15", sync_out, m_out);

        // R7 restart, R6 cancel
        wr(8'h23, 16'h5555); repeat (5) @(negedge clk);
        play(3, 16'h3C96);
        wr(8'h20, 16'hFFFF); repeat (3) @(negedge clk);
        wr(8'h10, 16'h0000); m_out[0] = 0;
        repeat (20) begin
            chk("R6 level cancels pattern", sync_out, m_out);
            @(negedge clk);
        end

        // R10 stray writes
        set_in(8'h3C);
        wr(8'h15, 16'h0001); wr(8'h25, 16'hFFFF); wr(8'h05, 16'hFFFF);
        wr(8'h01, 16'hFFFF); wr(8'h02, 16'hFFFF); wr(8'h00, 16'hFFFF);
        repeat (2) @(negedge clk);
        chk("R10 outputs untouched", sync_out, m_out);
        rd(8'h01, d); chk("R10 rise untouched", d, {8'h0, m_rise}); m_rise = '0;
        rd(8'h02, d); chk("R10 fall untouched", d, {8'h0, m_fall}); m_fall = '0;

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = $urandom % 4;
            case (op)
                0: begin
                    int n;
                    n = 1 + $urandom % 8;
                    for (int i = 0; i < n; i++) set_in(8'($urandom));
                    chk_flags();
                end
                1: begin
                    rd(8'h00, d); chk("R2 random value", d, {8'h0, m_val});
                end
                2: begin
                    int k; logic b;
                    k = $urandom % N_OUT; b = 1'($urandom);
                    wr(8'h10 + 8'(k), {15'h0, b}); m_out[k] = b;
                    chk("R6 random level", sync_out, m_out);
                end
                default: play($urandom % N_OUT, 16'($urandom));
            endcase
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule